// File: doc/BRIEF.md
# Dual-Edge Sync Pulse Timer

This block makes one repeating active-low pulse, such as a horizontal sync for a video line. A timer counter steps once every (prescale + 1) clocks and runs from zero up to one less than the programmed period, then wraps. Two compare values place the pulse inside the period. The output falls when the counter reaches the fall compare value and rises again when it reaches the rise compare value. The pulse can start and end at any count, and it may span the wrap point.

Software sets the block up through a single-cycle write port. It writes the prescale, the period, the two compare values, a channel configuration word (double-edge select and output drive enable) and a run-control word. The period and both compare values are double-buffered. While the timer runs, a new value is taken into use only when the counter wraps. While the timer is stopped, it is taken into use at once.

Top module: `dual_edge_sync_timer`

## Requirements
- R1: A synchronous active-low reset clears every register and both counters, and drives `syncN` high.
- R2: The timer counter advances once every (prescale + 1) clocks. The prescale is written at address 1, so one line lasts period × (prescale + 1) clocks.
- R3: The period is written at address 2. The counter runs 0 … period−1 and then returns to 0, so a line is exactly `period` counts long. A compare value of period−1 is the last reachable count.
- R4: In double-edge mode with fall < rise, `syncN` is low while the count is in [fall, rise), for (rise − fall) counts. The rise compare is at address 3 and the fall compare is at address 4.
- R5: In double-edge mode with fall > rise, the low pulse spans the wrap. `syncN` is low for counts ≥ fall and counts < rise, which is (period − fall + rise) counts.
- R6: In double-edge mode with fall equal to rise, `syncN` stays high for the whole line.
- R7: With the double-edge bit clear, `syncN` is low from count 0 until the rise compare, for `rise` counts.
- R8: The channel configuration is written at address 5. Bit 0 selects double-edge mode and bit 1 enables the output drive. When bit 1 is clear, `syncN` stays high.
- R9: The run control is written at address 0. Bit 0 enables counting and bit 1 enables pulse mode. The timer runs and the pulse appears only when both bits are set.
- R10: Clearing a run bit freezes both counters and forces `syncN` high. When the run bits are set again, counting resumes from the frozen count, so the pulse in progress ends with its remaining counts.
- R11: The period and compare values written while the timer runs take effect only from the next wrap. The pulse already in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | ADDR_W (3) | Register address |
| wrData | input | CNT_W (16) | Write data |
| syncN | output | 1 | Active-low pulse output |

## Verification
A wrong prescale count or a wrong wrap point changes how long the line is. This shows on `syncN` as a wrong distance between two falling edges, one line after the fault. A stray reload of the double-buffered registers in the middle of a line changes the length of the pulse already under way. A counter that slips while stopped leaves the wrong number of low counts after the timer resumes. The bench measures each pulse and each line in clocks. A wrong internal count therefore shows up within one line.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;
  localparam int unsigned ADDR_RUN    = 0;
  localparam int unsigned ADDR_PRESC  = 1;
  localparam int unsigned ADDR_PERIOD = 2;
  localparam int unsigned ADDR_RISE   = 3;
  localparam int unsigned ADDR_FALL   = 4;
  localparam int unsigned ADDR_CFG    = 5;

  typedef struct packed {
    logic run;    // both run-control bits set
    logic tick;   // prescaler expires this cycle
    logic dbl;    // double-edge mode
    logic drive;  // output drive enabled
  } strobe_t;
endpackage

// File: rtl/pulse_ctrl.sv
module pulse_ctrl
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  pendPeriod,
  output logic [CNT_W-1:0]  pendRise,
  output logic [CNT_W-1:0]  pendFall
);
  logic [1:0]       runReg;
  logic [1:0]       cfgReg;
  logic [CNT_W-1:0] prescReg;
  logic [CNT_W-1:0] preCnt;
  logic             runNow;
  logic             tickNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg     <= '0;
      cfgReg     <= '0;
      prescReg   <= '0;
      pendPeriod <= '0;
      pendRise   <= '0;
      pendFall   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(ADDR_RUN):    runReg     <= wrData[1:0];
        ADDR_W'(ADDR_PRESC):  prescReg   <= wrData;
        ADDR_W'(ADDR_PERIOD): pendPeriod <= wrData;
        ADDR_W'(ADDR_RISE):   pendRise   <= wrData;
        ADDR_W'(ADDR_FALL):   pendFall   <= wrData;
        ADDR_W'(ADDR_CFG):    cfgReg     <= wrData[1:0];
        default: ;
      endcase
    end
  end

  assign runNow  = &runReg;
  assign tickNow = runNow && (preCnt >= prescReg);

  always_ff @(posedge clk) begin
    if (!rstN)        preCnt <= '0;
    else if (tickNow) preCnt <= '0;
    else if (runNow)  preCnt <= preCnt + CNT_W'(1);
  end

  always_comb begin
    strb.run   = runNow;
    strb.tick  = tickNow;
    strb.dbl   = cfgReg[0];
    strb.drive = cfgReg[1];
  end

  // R10: the prescaler is frozen while stopped
  a_r10_prescale_hold: assert property (@(posedge clk) disable iff (!rstN)
    !runNow |=> $stable(preCnt));
  // R2: after a tick the prescaler restarts from zero
  a_r2_prescale_restart: assert property (@(posedge clk) disable iff (!rstN)
    tickNow |=> preCnt == '0);
endmodule

// File: rtl/pulse_datapath.sv
module pulse_datapath
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] pendPeriod,
  input  logic [CNT_W-1:0] pendRise,
  input  logic [CNT_W-1:0] pendFall,
  output logic             syncN
);
  localparam logic [CNT_W:0] ONE_EXT = (CNT_W+1)'(1);

  logic [CNT_W-1:0] perAct;
  logic [CNT_W-1:0] riseAct;
  logic [CNT_W-1:0] fallAct;
  logic [CNT_W-1:0] tc;
  logic             wrapNow;
  logic             loadNow;
  logic             inWin;

  assign wrapNow = strb.tick && (({1'b0, tc} + ONE_EXT) >= {1'b0, perAct});
  assign loadNow = !strb.run || wrapNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perAct  <= '0;
      riseAct <= '0;
      fallAct <= '0;
    end else if (loadNow) begin
      perAct  <= pendPeriod;
      riseAct <= pendRise;
      fallAct <= pendFall;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          tc <= '0;
    else if (wrapNow)   tc <= '0;
    else if (strb.tick) tc <= tc + CNT_W'(1);
  end

  always_comb begin
    if (!strb.dbl)              inWin = tc < riseAct;
    else if (fallAct < riseAct) inWin = (tc >= fallAct) && (tc < riseAct);
    else if (fallAct > riseAct) inWin = (tc >= fallAct) || (tc < riseAct);
    else                        inWin = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncN <= 1'b1;
    else       syncN <= !(strb.run && strb.drive && inWin);
  end

  // R10: stopped timer holds its count and idles the output
  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> $stable(tc));
  a_r10_output_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> syncN);
  // R3: a wrap returns the count to zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> tc == '0);
  // R2: a tick without wrap steps the count by one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !wrapNow) |=> tc == $past(tc) + CNT_W'(1));
  // R6: equal compares keep the output high
  a_r6_equal_edges: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dbl && riseAct == fallAct) |=> syncN);
  // R11: compares stay fixed inside a running line
  a_r11_no_midline_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !wrapNow) |=> $stable(riseAct) && $stable(fallAct) && $stable(perAct));
endmodule

// File: rtl/dual_edge_sync_timer.sv
module dual_edge_sync_timer
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              syncN
);
  strobe_t          strb;
  logic [CNT_W-1:0] pendPeriod;
  logic [CNT_W-1:0] pendRise;
  logic [CNT_W-1:0] pendFall;

  pulse_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .pendPeriod(pendPeriod), .pendRise(pendRise), .pendFall(pendFall)
  );

  pulse_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pendPeriod(pendPeriod), .pendRise(pendRise), .pendFall(pendFall),
    .syncN(syncN)
  );

  // R1: output released high in the cycle after reset
  a_r1_reset_high: assert property (@(posedge clk) !rstN |=> syncN);
endmodule

// File: tb/test_dual_edge_sync_timer.sv
module test_dual_edge_sync_timer;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 3;
  localparam int NV = 6;
  localparam int TMO = 10000;
  // cfg, presc, period, rise, fall, expLowClk, expLineClk
  localparam int VEC [NV][7] = '{
    '{3, 3, 20, 17, 13, 16, 80},      // R2 R4
    '{3, 0, 10, 7, 2, 5, 10},         // R3 R4
    '{3, 1, 10, 2, 8, 8, 20},         // R5 wrap-spanning pulse
    '{2, 1, 10, 4, 0, 8, 20},         // R7 single-edge
    '{3, 2, 12, 11, 0, 33, 36},       // R3 compare at last count
    '{3, 3, 800, 752, 656, 384, 3200} // R2 R4 full video line
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic syncN;
  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dual_edge_sync_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dual_edge_sync_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .syncN(syncN)
  );

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      finishUp();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setup(input int cfg, input int ps, input int per, input int ri, input int fa);
    wr(0, 0); wr(1, ps); wr(2, per); wr(3, ri); wr(4, fa); wr(5, cfg); wr(0, 3);
  endtask

  task automatic waitLevel(input logic lvl);
    int n = 0;
    while (syncN !== lvl && n < TMO) begin @(negedge clk); n++; end
  endtask

  task automatic countLevel(input logic lvl, output int n);
    n = 0;
    while (syncN === lvl && n < TMO) begin n++; @(negedge clk); end
  endtask

  task automatic watchHigh(input string req, input int clks);
    int lows = 0;
    for (int i = 0; i < clks; i++) begin
      if (syncN !== 1'b1) lows++;
      @(negedge clk);
    end
    check(req, lows, 0);
  endtask

  initial begin
    int lo, hi, l1, l2;
    @(negedge clk); @(negedge clk);
    check("R1 reset output", int'(syncN), 1);
    rstN = 1'b1;
    @(negedge clk);
    wr(0, 3);
    watchHigh("R1 cleared registers idle", 40);

    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      waitLevel(1'b0); waitLevel(1'b1); waitLevel(1'b0);
      countLevel(1'b0, lo);
      countLevel(1'b1, hi);
      check($sformatf("R2 R4 vec%0d low clocks", v), lo, VEC[v][5]);
      check($sformatf("R3 vec%0d line clocks", v), lo + hi, VEC[v][6]);
    end

    setup(3, 0, 10, 5, 5);
    watchHigh("R6 equal compares", 40);
    setup(1, 0, 10, 7, 2);
    watchHigh("R8 drive disabled", 40);
    setup(3, 0, 10, 7, 2);
    wr(0, 1);
    watchHigh("R9 count bit only", 30);
    wr(0, 2);
    watchHigh("R9 pulse bit only", 30);

    // R10: stop in mid-pulse, then resume
    setup(3, 0, 20, 17, 13);
    waitLevel(1'b0); waitLevel(1'b1); waitLevel(1'b0);
    l1 = 1;
    wr(0, 0);
    countLevel(1'b0, lo);
    l1 += lo;
    watchHigh("R10 stopped output high", 50);
    wr(0, 3);
    waitLevel(1'b0);
    countLevel(1'b0, l2);
    check("R10 resumed pulse total counts", l1 + l2, 4);

    // R11: rise moved during a pulse, takes effect next line
    setup(3, 0, 20, 17, 13);
    waitLevel(1'b0); waitLevel(1'b1); waitLevel(1'b0);
    lo = 1;
    wr(3, 19);
    countLevel(1'b0, l1);
    check("R11 current pulse unchanged", lo + l1, 4);
    waitLevel(1'b0);
    countLevel(1'b0, l2);
    check("R11 next pulse updated", l2, 6);

    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 reset mid-run", int'(syncN), 1);
    finishUp();
  end
endmodule